// File: doc/BRIEF.md
# Interrupt Gate Validation Checker

This block screens an interrupt or exception vector against the interrupt descriptor table before the processor dispatches it. A request carries the vector, the table limit, the operating mode (real, protected, virtual-8086 inside protected), the I/O privilege level, the current privilege level, a flag saying whether the event is a software interrupt instruction, and the 64-bit gate descriptor already fetched for that vector. The descriptor is ignored in real mode.

One clock after each request the block emits a single-cycle result. The result is one of two things:
- a dispatch verdict: the real-mode table entry offset, or the gate kind, its width, its entry offset and its target selector;
- a general-protection fault with the exact error code the processor must push.

The checks run in a fixed priority order, and only the first failing check is reported. Fetching the descriptor, performing a task switch and checking the target code segment are done elsewhere.

Top module: `intr_gate_screen`

## Requirements
- R1: Every cycle with `req_valid` high yields exactly one cycle of `res_valid` on the next clock edge. A cycle without a request yields no `res_valid` on the next edge. Requests may arrive on consecutive cycles.
- R2: In real mode (`prot_mode`=0), the entry ends at vector*4+3. If that value exceeds `idt_limit`, the block faults with error code vector*4 | 2 (bit 1 set, bit 0 clear). Otherwise it dispatches with `res_kind`=00, `res_wide`=0, `res_offset`=vector*4 and `res_selector`=0.
- R3: In protected mode, the entry ends at vector*8+7. If that value exceeds `idt_limit`, the block faults with error code vector*8 | 2 | X, where bit 0 (X) is 1 when `soft_int`=0 and 0 when `soft_int`=1.
- R4: In protected mode with `v86_mode`=1, a software interrupt (`soft_int`=1) while `iopl` is below 3 faults with error code 0. `v86_mode` has no effect when `prot_mode`=0.
- R5: Descriptor bit 47 is the present flag, bits 46:45 are the gate privilege level and bits 44:40 are the 5-bit type. In protected mode a gate with present=0 faults with error code vector*8 | 2 | X.
- R6: The only legal types are 00101 (task), 0w110 (interrupt) and 0w111 (trap), where w=1 means a 32-bit gate. Any other type faults with error code vector*8 | 2 | X.
- R7: For a software interrupt, a gate privilege level numerically below `cpl` faults with error code vector*8 | 2, with bit 0 clear. Hardware events skip this check.
- R8: The checks are ranked V86/IOPL first, then limit, then present/type, then privilege level. Only the highest-ranked failure is reported.
- R9: A passing protected-mode request reports `res_kind` 01 for a task gate, 10 for an interrupt gate and 11 for a trap gate. `res_wide` equals the type's w bit for interrupt and trap gates and is 0 for task gates.
- R10: On a protected-mode dispatch, `res_selector` is descriptor bits 31:16. For interrupt and trap gates, `res_offset` is {descriptor bits 63:48, descriptor bits 15:0}. For task gates it is 0.
- R11: While reset is held, and afterwards until the first result, every output is 0.
- R12: A fault result carries `res_kind`=00, `res_wide`=0, `res_offset`=0 and `res_selector`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| vector | input | 8 | Interrupt vector number |
| idt_limit | input | 32 | Descriptor table limit (last valid byte offset) |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| v86_mode | input | 1 | Virtual-8086 mode, meaningful in protected mode only |
| iopl | input | 2 | Current I/O privilege level |
| cpl | input | 2 | Current privilege level |
| soft_int | input | 1 | 1 = software interrupt instruction, 0 = external event or exception |
| gate_desc | input | 64 | Fetched gate descriptor (high word in bits 63:32) |
| res_valid | output | 1 | Result strobe, one cycle |
| res_fault | output | 1 | 1 = general-protection fault |
| res_err_code | output | 16 | Fault error code, 0 on dispatch |
| res_kind | output | 2 | Dispatch kind: 00 real, 01 task, 10 interrupt, 11 trap |
| res_wide | output | 1 | 1 = 32-bit interrupt or trap gate |
| res_offset | output | 32 | Entry offset of the handler (or real-mode table entry offset) |
| res_selector | output | 16 | Target selector from the gate |

## Verification
Several checks can fail within the same request. The case that changes the reported code is a software interrupt in virtual-8086 mode with low I/O privilege whose table entry also lies past the limit: it must report error code 0 and not the limit code. The bench provokes this collision and also pairs a missing or illegal gate with a privilege failure. The scoreboard judges each result by the complete error code, including bit 0, and by the blanked dispatch fields. Back-to-back requests check that one result can leave while the next request is being screened.

// File: rtl/igs_pkg.sv
// Package: shared constants and types for the interrupt gate screen.
// Assumes the architectural 64-bit gate descriptor layout.
package igs_pkg;

    localparam int DESC_W = 64;

    // Dispatch kind reported with a passing request.
    typedef enum logic [1:0] {
        KIND_REAL = 2'b00,
        KIND_TASK = 2'b01,
        KIND_INTR = 2'b10,
        KIND_TRAP = 2'b11
    } gate_kind_e;

    localparam logic [4:0] TYPE_TASK = 5'b00101;

endpackage

// File: rtl/igs_bounds.sv
// Module: igs_bounds
// Computes the last byte of the table entry for the vector in both entry
// scales (4-byte real-mode slots, 8-byte protected-mode slots) and compares
// it against the table limit. Also gives the real-mode entry base offset.
// Assumes LIMIT_W and ADDR_W are both at least VEC_W + 3.
module igs_bounds #(
    parameter int VEC_W   = 8,
    parameter int LIMIT_W = 32,
    parameter int ADDR_W  = 32
) (
    input  logic [VEC_W-1:0]   vector,
    input  logic [LIMIT_W-1:0] idt_limit,
    input  logic               prot_mode,
    output logic               over_limit,
    output logic [ADDR_W-1:0]  real_base
);
    localparam int WIDE_SRC = (LIMIT_W > VEC_W + 3) ? LIMIT_W : VEC_W + 3;
    localparam int CMP_W    = WIDE_SRC + 1;

    logic [CMP_W-1:0] entry_last [2];
    logic [1:0]       past_end;

    // One comparator per entry scale: index 0 = 4-byte slots, 1 = 8-byte slots.
    for (genvar m = 0; m < 2; m++) begin : g_scale
        localparam int SH = 2 + m;
        assign entry_last[m] = (CMP_W'(vector) << SH) | CMP_W'((1 << SH) - 1);
        assign past_end[m]   = entry_last[m] > CMP_W'(idt_limit);
    end

    // Select the comparator matching the current mode.
    assign over_limit = prot_mode ? past_end[1] : past_end[0];

    // Real-mode entry base is the 4-byte slot start.
    assign real_base = ADDR_W'(vector) << 2;

endmodule

// File: rtl/igs_gate_decode.sv
// Module: igs_gate_decode
// Splits a fetched gate descriptor into present flag, privilege level,
// legality of the type, dispatch kind, width, entry offset and selector.
// Assumes the high word sits in bits 63:32 of the descriptor.
module igs_gate_decode
    import igs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [DESC_W-1:0] gate_desc,
    output logic              present,
    output logic [1:0]        gate_dpl,
    output logic              legal,
    output gate_kind_e        kind,
    output logic              wide,
    output logic [ADDR_W-1:0] entry_ofs,
    output logic [SEL_W-1:0]  selector
);
    logic [31:0] hi_word;
    logic [31:0] lo_word;
    logic [4:0]  gtype;
    logic        is_task;
    logic        is_gate;
    logic        unused_desc_bits;

    assign hi_word = gate_desc[63:32];
    assign lo_word = gate_desc[31:0];
    assign gtype   = hi_word[12:8];
    assign present = hi_word[15];
    assign gate_dpl = hi_word[14:13];
    assign unused_desc_bits = ^hi_word[7:0];

    // Classify the type field: task gate or interrupt/trap gate of either width.
    assign is_task = (gtype == TYPE_TASK);
    assign is_gate = !gtype[4] && (gtype[2:1] == 2'b11);
    assign legal   = is_task || is_gate;

    // Map the classified type to a dispatch kind.
    always_comb begin
        if (is_task)      kind = KIND_TASK;
        else if (is_gate) kind = gtype[0] ? KIND_TRAP : KIND_INTR;
        else              kind = KIND_REAL;
    end

    // Width flag exists only for interrupt and trap gates.
    assign wide = is_gate && gtype[3];

    // Handler offset is split across both words; task gates carry none.
    assign entry_ofs = is_gate ? ADDR_W'({hi_word[31:16], lo_word[15:0]}) : '0;
    assign selector  = SEL_W'(lo_word[31:16]);

endmodule

// File: rtl/igs_arbiter.sv
// Module: igs_arbiter
// Ranks the individual check outcomes (V86/IOPL, limit, present/type,
// privilege) and forms the single verdict for the request: a fault with its
// error code, or the dispatch fields. Purely combinational.
// Assumes ERR_W is at least VEC_W + 3.
module igs_arbiter
    import igs_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ERR_W  = 16,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [VEC_W-1:0]  vector,
    input  logic              prot_mode,
    input  logic              v86_mode,
    input  logic [1:0]        iopl,
    input  logic [1:0]        cpl,
    input  logic              soft_int,
    input  logic              over_limit,
    input  logic [ADDR_W-1:0] real_base,
    input  logic              present,
    input  logic [1:0]        gate_dpl,
    input  logic              legal,
    input  gate_kind_e        gate_kind,
    input  logic              gate_wide,
    input  logic [ADDR_W-1:0] gate_ofs,
    input  logic [SEL_W-1:0]  gate_sel,
    output logic              nxt_fault,
    output logic [ERR_W-1:0]  nxt_err,
    output gate_kind_e        nxt_kind,
    output logic              nxt_wide,
    output logic [ADDR_W-1:0] nxt_ofs,
    output logic [SEL_W-1:0]  nxt_sel
);
    logic             ext_bit;
    logic [ERR_W-1:0] real_code;
    logic [ERR_W-1:0] prot_code;
    logic             v86_block;
    logic             gate_bad;
    logic             dpl_bad;

    // External-event flag placed in bit 0 of protected-mode codes.
    assign ext_bit = !soft_int;

    // Table-index error codes for both entry scales, bit 1 marks the table.
    assign real_code = (ERR_W'(vector) << 2) | ERR_W'(2);
    assign prot_code = (ERR_W'(vector) << 3) | ERR_W'(2);

    // Individual check outcomes in protected mode.
    assign v86_block = v86_mode && soft_int && (iopl != 2'd3);
    assign gate_bad  = !present || !legal;
    assign dpl_bad   = soft_int && (gate_dpl < cpl);

    // Priority resolution: first failing check wins, dispatch otherwise.
    always_comb begin
        nxt_fault = 1'b0;
        nxt_err   = '0;
        nxt_kind  = KIND_REAL;
        nxt_wide  = 1'b0;
        nxt_ofs   = '0;
        nxt_sel   = '0;
        if (!prot_mode) begin
            if (over_limit) begin
                nxt_fault = 1'b1;
                nxt_err   = real_code;
            end else begin
                nxt_ofs = real_base;
            end
        end else if (v86_block) begin
            nxt_fault = 1'b1;
        end else if (over_limit || gate_bad) begin
            nxt_fault = 1'b1;
            nxt_err   = prot_code | ERR_W'(ext_bit);
        end else if (dpl_bad) begin
            nxt_fault = 1'b1;
            nxt_err   = prot_code;
        end else begin
            nxt_kind = gate_kind;
            nxt_wide = gate_wide;
            nxt_ofs  = gate_ofs;
            nxt_sel  = gate_sel;
        end
    end

endmodule

// File: rtl/intr_gate_screen.sv
// Module: intr_gate_screen (top)
// Validates an interrupt vector against the descriptor table and the fetched
// gate, then registers a one-cycle verdict: dispatch fields or a fault with
// its error code. Latency is one clock from request to result.
// Assumes the descriptor is presented in the same cycle as the request.
module intr_gate_screen
    import igs_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int LIMIT_W = 32,
    parameter int ERR_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   vector,
    input  logic [LIMIT_W-1:0] idt_limit,
    input  logic               prot_mode,
    input  logic               v86_mode,
    input  logic [1:0]         iopl,
    input  logic [1:0]         cpl,
    input  logic               soft_int,
    input  logic [63:0]        gate_desc,
    output logic               res_valid,
    output logic               res_fault,
    output logic [ERR_W-1:0]   res_err_code,
    output logic [1:0]         res_kind,
    output logic               res_wide,
    output logic [ADDR_W-1:0]  res_offset,
    output logic [SEL_W-1:0]   res_selector
);
    logic              over_limit;
    logic [ADDR_W-1:0] real_base;
    logic              present;
    logic [1:0]        gate_dpl;
    logic              legal;
    gate_kind_e        gate_kind;
    logic              gate_wide;
    logic [ADDR_W-1:0] gate_ofs;
    logic [SEL_W-1:0]  gate_sel;
    logic              nxt_fault;
    logic [ERR_W-1:0]  nxt_err;
    gate_kind_e        nxt_kind;
    logic              nxt_wide;
    logic [ADDR_W-1:0] nxt_ofs;
    logic [SEL_W-1:0]  nxt_sel;

    igs_bounds #(
        .VEC_W   (VEC_W),
        .LIMIT_W (LIMIT_W),
        .ADDR_W  (ADDR_W)
    ) u_bounds (
        .vector     (vector),
        .idt_limit  (idt_limit),
        .prot_mode  (prot_mode),
        .over_limit (over_limit),
        .real_base  (real_base)
    );

    igs_gate_decode #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_decode (
        .gate_desc (gate_desc),
        .present   (present),
        .gate_dpl  (gate_dpl),
        .legal     (legal),
        .kind      (gate_kind),
        .wide      (gate_wide),
        .entry_ofs (gate_ofs),
        .selector  (gate_sel)
    );

    igs_arbiter #(
        .VEC_W  (VEC_W),
        .ERR_W  (ERR_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_arbiter (
        .vector     (vector),
        .prot_mode  (prot_mode),
        .v86_mode   (v86_mode),
        .iopl       (iopl),
        .cpl        (cpl),
        .soft_int   (soft_int),
        .over_limit (over_limit),
        .real_base  (real_base),
        .present    (present),
        .gate_dpl   (gate_dpl),
        .legal      (legal),
        .gate_kind  (gate_kind),
        .gate_wide  (gate_wide),
        .gate_ofs   (gate_ofs),
        .gate_sel   (gate_sel),
        .nxt_fault  (nxt_fault),
        .nxt_err    (nxt_err),
        .nxt_kind   (nxt_kind),
        .nxt_wide   (nxt_wide),
        .nxt_ofs    (nxt_ofs),
        .nxt_sel    (nxt_sel)
    );

    // Result register: capture the verdict for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_fault    <= 1'b0;
            res_err_code <= '0;
            res_kind     <= KIND_REAL;
            res_wide     <= 1'b0;
            res_offset   <= '0;
            res_selector <= '0;
        end else if (req_valid) begin
            res_valid    <= 1'b1;
            res_fault    <= nxt_fault;
            res_err_code <= nxt_err;
            res_kind     <= nxt_kind;
            res_wide     <= nxt_wide;
            res_offset   <= nxt_ofs;
            res_selector <= nxt_sel;
        end else begin
            res_valid    <= 1'b0;
            res_fault    <= 1'b0;
            res_err_code <= '0;
            res_kind     <= KIND_REAL;
            res_wide     <= 1'b0;
            res_offset   <= '0;
            res_selector <= '0;
        end
    end

    // R1: each request produces a result on the next edge.
    p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R1: no request, no result.
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R2: real-mode results never name a gate kind or width.
    p_real_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> (res_kind == KIND_REAL && !res_wide));

    // R4: V86 software interrupt with low IOPL faults with code 0.
    p_v86_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && v86_mode && soft_int && iopl != 2'd3)
        |=> (res_fault && res_err_code == '0));

    // R7: a software source never sets the external bit in any code.
    p_soft_no_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && soft_int) |=> !res_err_code[0]);

    // R9: the width flag appears only with interrupt or trap gates.
    p_wide_gate_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_wide) |-> res_kind[1]);

    // R12: a fault blanks every dispatch field.
    p_fault_blank_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault)
        |-> (res_kind == KIND_REAL && !res_wide && res_offset == '0 && res_selector == '0));

endmodule

// File: tb/intr_gate_screen_test.sv
// Scoreboard bench: a driver task pushes expected results, a monitor pops and compares.
module intr_gate_screen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  vector = '0;
    logic [31:0] idt_limit = '0;
    logic        prot_mode = 1'b0;
    logic        v86_mode = 1'b0;
    logic [1:0]  iopl = '0;
    logic [1:0]  cpl = '0;
    logic        soft_int = 1'b0;
    logic [63:0] gate_desc = '0;
    logic        res_valid;
    logic        res_fault;
    logic [15:0] res_err_code;
    logic [1:0]  res_kind;
    logic        res_wide;
    logic [31:0] res_offset;
    logic [15:0] res_selector;

    int n_checks = 0;
    int n_fail = 0;
    logic [67:0] exp_q[$];
    string       tag_q[$];

    intr_gate_screen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vector(vector),
        .idt_limit(idt_limit), .prot_mode(prot_mode), .v86_mode(v86_mode),
        .iopl(iopl), .cpl(cpl), .soft_int(soft_int), .gate_desc(gate_desc),
        .res_valid(res_valid), .res_fault(res_fault), .res_err_code(res_err_code),
        .res_kind(res_kind), .res_wide(res_wide), .res_offset(res_offset),
        .res_selector(res_selector)
    );

    always #4 clk = ~clk;

    // Build a descriptor: present, privilege, type, selector, offset.
    function automatic logic [63:0] mk(input logic p, input logic [1:0] dl,
                                       input logic [4:0] t, input logic [15:0] sel,
                                       input logic [31:0] ofs);
        return {ofs[31:16], p, dl, t, 8'h00, sel, ofs[15:0]};
    endfunction

    // Expected verdict from the requirements: {fault, err, kind, wide, offset, selector}.
    function automatic logic [67:0] model(input logic [7:0] v, input logic [31:0] lim,
                                          input logic pm, input logic vm,
                                          input logic [1:0] io, input logic [1:0] cp,
                                          input logic sw, input logic [63:0] d);
        logic [15:0] ecode;
        logic [4:0]  t;
        logic        ok_type;
        logic        gate_like;
        t = d[44:40];
        gate_like = (t[4] == 1'b0) && (t[2:1] == 2'b11);
        ok_type = (t == 5'b00101) || gate_like;
        ecode = {5'b0, v, 3'b010};
        if (!pm) begin
            if (({24'b0, v} * 4 + 3) > lim) return {1'b1, {6'b0, v, 2'b10}, 2'b00, 1'b0, 32'h0, 16'h0};
            return {1'b0, 16'h0, 2'b00, 1'b0, {22'b0, v, 2'b00}, 16'h0};
        end
        if (vm && sw && io != 2'd3) return {1'b1, 16'h0, 2'b00, 1'b0, 32'h0, 16'h0};
        if ((({24'b0, v} * 8 + 7) > lim) || !d[47] || !ok_type)
            return {1'b1, ecode | {15'b0, !sw}, 2'b00, 1'b0, 32'h0, 16'h0};
        if (sw && d[46:45] < cp) return {1'b1, ecode, 2'b00, 1'b0, 32'h0, 16'h0};
        if (!gate_like) return {1'b0, 16'h0, 2'b01, 1'b0, 32'h0, d[31:16]};
        return {1'b0, 16'h0, t[0] ? 2'b11 : 2'b10, t[3], {d[63:48], d[15:0]}, d[31:16]};
    endfunction

    // Driver: apply one request at the falling edge and queue its expectation.
    task automatic send(input string tag, input logic [7:0] v, input logic [31:0] lim,
                        input logic pm, input logic vm, input logic [1:0] io,
                        input logic [1:0] cp, input logic sw, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; vector = v; idt_limit = lim; prot_mode = pm; v86_mode = vm;
        iopl = io; cpl = cp; soft_int = sw; gate_desc = d;
        exp_q.push_back(model(v, lim, pm, vm, io, cp, sw, d));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pop and compare every result away from the active edge.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            logic [67:0] act;
            act = {res_fault, res_err_code, res_kind, res_wide, res_offset, res_selector};
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected result act=%h exp=none", act);
            end else begin
                logic [67:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", t, act, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    localparam logic [4:0] T_TASK = 5'b00101, T_I16 = 5'b00110, T_I32 = 5'b01110,
                           T_T16 = 5'b00111, T_T32 = 5'b01111;

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs zero while reset is held.
        n_checks++;
        if ({res_valid, res_fault, res_err_code, res_kind, res_wide, res_offset, res_selector} !== '0) begin
            n_fail++;
            $display("FAIL R11 reset outputs act=%h exp=0", {res_valid, res_err_code, res_offset});
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 valid after reset act=%b exp=0", res_valid);
        end

        // R2: real mode, inside, exact boundary, just past, v86 ignored (R4).
        send("R2 real inside", 8'h10, 32'h3FF, 0, 0, 0, 0, 1, 64'h0);
        send("R2 real boundary ok", 8'hFF, 32'h3FF, 0, 0, 0, 0, 0, 64'h0);
        send("R2 real past limit", 8'hFF, 32'h3FE, 0, 0, 0, 0, 0, 64'h0);
        send("R4 v86 ignored in real mode", 8'h21, 32'h3FF, 0, 1, 0, 0, 1, 64'h0);
        idle();

        // R3: protected limit boundary, both sources.
        send("R3 prot boundary ok", 8'h20, 32'h107, 1, 0, 0, 0, 0, mk(1, 0, T_I32, 16'h0008, 32'h1234_5678));
        send("R3 prot past limit soft", 8'h20, 32'h106, 1, 0, 0, 0, 1, mk(1, 3, T_I32, 16'h0008, 32'h0));
        send("R3 prot past limit ext", 8'h20, 32'h106, 1, 0, 0, 0, 0, mk(1, 0, T_I32, 16'h0008, 32'h0));
        idle();

        // R4 and R8: V86 rule beats the limit; IOPL 3 and hardware pass it.
        send("R4 R8 v86 low iopl over limit", 8'hF0, 32'h10, 1, 1, 2, 0, 1, mk(1, 3, T_T32, 16'h10, 32'h0));
        send("R4 v86 iopl3 passes", 8'h30, 32'h7FF, 1, 1, 3, 3, 1, mk(1, 3, T_T32, 16'h0010, 32'hCAFE_0001));
        send("R4 v86 hardware passes", 8'h30, 32'h7FF, 1, 1, 0, 3, 0, mk(1, 0, T_I16, 16'h0018, 32'h0000_4000));
        idle();

        // R5, R6: absent gate and illegal types.
        send("R5 not present ext", 8'h0E, 32'h7FF, 1, 0, 0, 0, 0, mk(0, 0, T_I32, 16'h8, 32'h0));
        send("R6 call-gate type", 8'h0D, 32'h7FF, 1, 0, 0, 0, 0, mk(1, 0, 5'b01100, 16'h8, 32'h0));
        send("R6 type top bit set", 8'h0D, 32'h7FF, 1, 0, 0, 0, 1, mk(1, 3, 5'b11110, 16'h8, 32'h0));
        send("R6 R8 bad type and low dpl soft", 8'h41, 32'h7FF, 1, 0, 0, 3, 1, mk(1, 0, 5'b00100, 16'h8, 32'h0));
        idle();

        // R7: privilege rule for software only.
        send("R7 soft dpl below cpl", 8'h80, 32'h7FF, 1, 0, 0, 3, 1, mk(1, 0, T_T32, 16'h0008, 32'h0000_1000));
        send("R7 hardware skips dpl", 8'h80, 32'h7FF, 1, 0, 0, 3, 0, mk(1, 0, T_T32, 16'h0008, 32'h0000_1000));
        send("R7 soft dpl equal", 8'h80, 32'h7FF, 1, 0, 0, 2, 1, mk(1, 2, T_T32, 16'h0008, 32'h0000_1000));
        idle();

        // R9, R10: every dispatch kind, back to back (R1).
        send("R9 R10 task gate", 8'h08, 32'h7FF, 1, 0, 0, 0, 0, mk(1, 0, T_TASK, 16'h0028, 32'hFFFF_FFFF));
        send("R9 R10 interrupt 16", 8'h09, 32'h7FF, 1, 0, 0, 0, 0, mk(1, 0, T_I16, 16'h0030, 32'h0000_ABCD));
        send("R9 R10 interrupt 32", 8'h0A, 32'h7FF, 1, 0, 0, 0, 0, mk(1, 0, T_I32, 16'h0038, 32'h8765_4321));
        send("R9 R10 trap 16", 8'h0B, 32'h7FF, 1, 0, 0, 0, 0, mk(1, 0, T_T16, 16'h0040, 32'h0000_1111));
        send("R9 R10 trap 32", 8'h0C, 32'h7FF, 1, 0, 0, 0, 0, mk(1, 0, T_T32, 16'h0048, 32'hDEAD_BEEF));
        idle();
        repeat (3) @(negedge clk);

        // R1: nothing left outstanding.
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 missing results act=%0d exp=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule